// File: doc/BRIEF.md
# Segment Access Permission Checker

This block screens one memory access against a cached segment descriptor before the access is allowed to reach memory. Each request carries the access kind, the offset into the segment and the access size in bytes. It also carries the descriptor's base, limit, expand-down flag, present bit, descriptor privilege, requester privilege, executable flag and read/write flag, along with the current privilege level and a protected-mode enable.

One clock after a valid request, the block raises exactly one of two strobes for a single cycle. The pass strobe comes with the 32-bit linear address. The fault strobe comes with a fault class that the exception logic turns into a general protection or a not-present fault. The checks are taken in a fixed order: the limit first, then presence, then privilege, then segment type. When several checks fail, the first failing one sets the class.

Top module: `seg_access_check`

## Requirements
- R1: One clock after `req_valid` is sampled high, exactly one of `pass_o` and `fault_o` is high for that cycle. In a cycle that follows a clock with `req_valid` low, both are low.
- R2: For a fetch (kind 2'b00), or for a data access (read 2'b01, write 2'b10) to a segment with `desc_expdown` low, the request gets a general protection fault when offset + size - 1 is greater than the limit. The sum is formed without 32-bit wrap-around, so an access that reaches exactly the limit passes.
- R3: For a data access to a segment with `desc_expdown` high, the request gets a general protection fault when the offset is below the limit. An offset equal to the limit passes the limit check. A fetch from such a segment still uses the R2 rule.
- R4: A limit violation is reported as general protection even when the descriptor would also fail the presence, privilege or type checks.
- R5: With `prot_en` low, only the limit check applies. Presence, privilege and type fields have no effect.
- R6: With `prot_en` high, a descriptor whose present bit is clear produces fault class 2'b10 (not-present).
- R7: With `prot_en` high, the request gets a general protection fault when CPL is greater than DPL. For reads and writes, but not for fetches, it also gets one when RPL is greater than DPL.
- R8: With `prot_en` high, a fetch from a segment with `desc_exec` low faults. A read from a segment with `desc_exec` high and `desc_rw` low (not readable) faults. Both faults are general protection.
- R9: With `prot_en` high, every write to a segment with `desc_exec` high faults. A write to a segment with `desc_exec` low and `desc_rw` low (not writable) faults. Both faults are general protection.
- R10: On pass, `lin_addr` equals base + offset modulo 2^32 and `fault_class` is 2'b00. On fault, `fault_class` is 2'b01 for general protection or 2'b10 for not-present, and `lin_addr` is 0. With no strobe, all outputs are 0.
- R11: In protected mode, presence is checked before privilege, and privilege before type. A descriptor that is both not present and privilege-violating reports 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write |
| req_offset | input | 32 | Offset within the segment |
| req_size | input | 3 | Access size in bytes, 1 or more |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 32 | Segment limit (byte granular) |
| desc_expdown | input | 1 | Expand-down data segment |
| desc_present | input | 1 | Present bit |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_rpl | input | 2 | Requester privilege of the selector |
| desc_exec | input | 1 | Code segment |
| desc_rw | input | 1 | Readable for code, writable for data |
| cur_pl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protected mode enabled |
| pass_o | output | 1 | Access allowed (one-cycle strobe) |
| fault_o | output | 1 | Access refused (one-cycle strobe) |
| fault_class | output | 2 | 00 none, 01 general protection, 10 not present |
| lin_addr | output | 32 | Linear address when `pass_o` is high |

## Verification
The assertions assume that `req_size` is at least one byte and that `req_kind` never carries the unused code 2'b11. Under those assumptions the limit sum and the kind decode have a single meaning. The driver task only issues sizes from 1 to 4 and the three defined kinds, so every request stays inside those assumptions. The boundary stimulus sits exactly at the limit, one byte past it, and at the top of the 32-bit offset range, where a wrapping sum would wrongly pass.

// File: rtl/seg_access_check.sv
module seg_access_check #(
  parameter int AW = 32,
  parameter int SW = 3,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_offset,
  input  logic [SW-1:0] req_size,
  input  logic [AW-1:0] desc_base,
  input  logic [AW-1:0] desc_limit,
  input  logic          desc_expdown,
  input  logic          desc_present,
  input  logic [PW-1:0] desc_dpl,
  input  logic [PW-1:0] desc_rpl,
  input  logic          desc_exec,
  input  logic          desc_rw,
  input  logic [PW-1:0] cur_pl,
  input  logic          prot_en,
  output logic          pass_o,
  output logic          fault_o,
  output logic [1:0]    fault_class,
  output logic [AW-1:0] lin_addr
);
  localparam int EW = AW + 1;
  localparam logic [1:0] CL_NONE = 2'b00;
  localparam logic [1:0] CL_GP   = 2'b01;
  localparam logic [1:0] CL_NP   = 2'b10;

  logic          is_fetch, is_write;
  logic [EW-1:0] end_off;
  logic          limit_bad, priv_bad, type_bad;
  logic [1:0]    cls_next;

  assign is_fetch = (req_kind == 2'b00);
  assign is_write = (req_kind == 2'b10);
  assign end_off  = {1'b0, req_offset} + EW'(req_size) - EW'(1);

  assign limit_bad = (is_fetch || !desc_expdown) ? (end_off > {1'b0, desc_limit})
                                                 : (req_offset < desc_limit);
  assign priv_bad  = (cur_pl > desc_dpl) || (!is_fetch && (desc_rpl > desc_dpl));
  assign type_bad  = is_fetch ? !desc_exec
                   : is_write ? (desc_exec || !desc_rw)
                   : (desc_exec && !desc_rw);

  always_comb begin
    if (limit_bad)                      cls_next = CL_GP;
    else if (!prot_en)                  cls_next = CL_NONE;
    else if (!desc_present)             cls_next = CL_NP;
    else if (priv_bad || type_bad)      cls_next = CL_GP;
    else                                cls_next = CL_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_o      <= 1'b0;
      fault_o     <= 1'b0;
      fault_class <= CL_NONE;
      lin_addr    <= '0;
    end else begin
      pass_o      <= req_valid && (cls_next == CL_NONE);
      fault_o     <= req_valid && (cls_next != CL_NONE);
      fault_class <= req_valid ? cls_next : CL_NONE;
      lin_addr    <= (req_valid && cls_next == CL_NONE) ? desc_base + req_offset : '0;
    end
  end

  assert_strobe_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (pass_o ^ fault_o));
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!pass_o && !fault_o));
  assert_class_matches_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o |-> fault_class != CL_NONE) and (pass_o |-> fault_class == CL_NONE));
  assert_pass_address_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!pass_o || lin_addr == $past(desc_base + req_offset)));
  assert_real_mode_no_np_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en) |=> (fault_class != CL_NP));
endmodule

// File: tb/seg_access_check_bench.sv
`timescale 1ns/1ps
module seg_access_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [31:0] req_offset = '0;
  logic [2:0]  req_size = 3'd1;
  logic [31:0] desc_base = '0;
  logic [31:0] desc_limit = '0;
  logic        desc_expdown = 1'b0;
  logic        desc_present = 1'b0;
  logic [1:0]  desc_dpl = '0;
  logic [1:0]  desc_rpl = '0;
  logic        desc_exec = 1'b0;
  logic        desc_rw = 1'b0;
  logic [1:0]  cur_pl = '0;
  logic        prot_en = 1'b0;
  logic        pass_o, fault_o;
  logic [1:0]  fault_class;
  logic [31:0] lin_addr;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic        pass;
    logic [1:0]  cls;
    logic [31:0] addr;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  seg_access_check u_seg_access_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_offset(req_offset), .req_size(req_size), .desc_base(desc_base),
    .desc_limit(desc_limit), .desc_expdown(desc_expdown), .desc_present(desc_present),
    .desc_dpl(desc_dpl), .desc_rpl(desc_rpl), .desc_exec(desc_exec), .desc_rw(desc_rw),
    .cur_pl(cur_pl), .prot_en(prot_en), .pass_o(pass_o), .fault_o(fault_o),
    .fault_class(fault_class), .lin_addr(lin_addr)
  );

  function automatic exp_t model(input logic [1:0] k, input logic [31:0] off, input logic [2:0] sz,
                                 input logic [31:0] base, input logic [31:0] lim, input logic ed,
                                 input logic pres, input logic [1:0] dpl, input logic [1:0] rpl,
                                 input logic ex, input logic rw, input logic [1:0] cpl, input logic pe);
    exp_t e;
    longint unsigned last;
    bit lim_fault;
    bit gp;
    last = longint'(off) + longint'(sz) - 1;
    if (k == 2'b00 || !ed) lim_fault = (last > longint'(lim));   // R2
    else                   lim_fault = (off < lim);              // R3
    e = '0;
    if (lim_fault) e.cls = 2'b01;                                // R4
    else if (pe) begin
      if (!pres) e.cls = 2'b10;                                  // R6, R11
      else begin
        gp = (cpl > dpl) || (k != 2'b00 && rpl > dpl);           // R7
        if (k == 2'b00) gp = gp || !ex;                          // R8
        else if (k == 2'b01) gp = gp || (ex && !rw);             // R8
        else gp = gp || ex || !rw;                               // R9
        if (gp) e.cls = 2'b01;
      end
    end
    e.pass = (e.cls == 2'b00);
    e.addr = e.pass ? base + off : 32'h0;                        // R10
    return e;
  endfunction

  task automatic issue(input logic [1:0] k, input logic [31:0] off, input logic [2:0] sz,
                       input logic [31:0] base, input logic [31:0] lim, input logic ed,
                       input logic pres, input logic [1:0] dpl, input logic [1:0] rpl,
                       input logic ex, input logic rw, input logic [1:0] cpl, input logic pe,
                       input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_offset = off; req_size = sz;
    desc_base = base; desc_limit = lim; desc_expdown = ed; desc_present = pres;
    desc_dpl = dpl; desc_rpl = rpl; desc_exec = ex; desc_rw = rw; cur_pl = cpl; prot_en = pe;
    exp_q.push_back(model(k, off, sz, base, lim, ed, pres, dpl, rpl, ex, rw, cpl, pe));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (pass_o || fault_o) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R1: strobe with no request pending, pass=%0b fault=%0b expected none",
                   pass_o, fault_o);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (pass_o !== e.pass || fault_o !== !e.pass || fault_class !== e.cls || lin_addr !== e.addr) begin
            n_fail++;
            $display("FAIL %s: pass=%0b fault=%0b class=%b addr=%h expected pass=%0b class=%b addr=%h",
                     t, pass_o, fault_o, fault_class, lin_addr, e.pass, e.cls, e.addr);
          end
        end
      end else if (exp_q.size() != 0) begin
        n_tests++;
        n_fail++;
        void'(exp_q.pop_front());
        $display("FAIL R1 (%s): no strobe, expected one of pass/fault", tag_q.pop_front());
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_tests++;
    if (pass_o !== 1'b0 || fault_o !== 1'b0 || fault_class !== 2'b00 || lin_addr !== 32'h0) begin
      n_fail++;
      $display("FAIL R10 reset: pass=%0b fault=%0b class=%b addr=%h expected all zero",
               pass_o, fault_o, fault_class, lin_addr);
    end
    // R5: real mode ignores presence, privilege and type
    issue(2'b10, 32'h10, 3'd4, 32'h1000, 32'hFF, 0, 0, 0, 3, 1, 0, 3, 0, "R5");
    // R2: real mode limit overflow by one byte
    issue(2'b01, 32'hFD, 3'd4, 32'h1000, 32'hFF, 0, 1, 0, 0, 0, 1, 0, 0, "R2");
    // R2: fetch ends exactly at limit passes
    issue(2'b00, 32'hFC, 3'd4, 32'h2000, 32'hFF, 0, 1, 0, 0, 1, 1, 0, 1, "R2");
    // R2: fetch one byte past limit
    issue(2'b00, 32'hFD, 3'd4, 32'h2000, 32'hFF, 0, 1, 0, 0, 1, 1, 0, 1, "R2");
    idle(2);
    // R2: no wrap at the top of the offset range
    issue(2'b01, 32'hFFFFFFFF, 3'd2, 32'h0, 32'hFFFFFFFF, 0, 1, 0, 0, 0, 1, 0, 1, "R2");
    // R3: expand-down, offset below limit
    issue(2'b01, 32'h7F, 3'd1, 32'h0, 32'h80, 1, 1, 0, 0, 0, 1, 0, 1, "R3");
    // R3: expand-down, offset equal to limit
    issue(2'b01, 32'h80, 3'd4, 32'h300, 32'h80, 1, 1, 0, 0, 0, 1, 0, 1, "R3");
    // R3: fetch on expand-down uses upper-bound rule
    issue(2'b00, 32'h10, 3'd1, 32'h0, 32'h80, 1, 1, 0, 0, 1, 1, 0, 1, "R3");
    idle(1);
    // R4: limit fault wins over not-present
    issue(2'b01, 32'h200, 3'd1, 32'h0, 32'hFF, 0, 0, 0, 3, 0, 1, 3, 1, "R4");
    // R6: not present
    issue(2'b01, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 0, 3, 0, 0, 1, 0, 1, "R6");
    // R11: not present beats privilege fault
    issue(2'b10, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 0, 0, 3, 1, 0, 3, 1, "R11");
    // R7: CPL above DPL
    issue(2'b00, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 1, 1, 0, 1, 1, 2, 1, "R7");
    // R7: RPL above DPL on read
    issue(2'b01, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 1, 1, 2, 0, 1, 0, 1, "R7");
    // R7: RPL above DPL on fetch is ignored
    issue(2'b00, 32'h4, 3'd1, 32'h500, 32'hFF, 0, 1, 1, 3, 1, 0, 1, 1, "R7");
    idle(3);
    // R8: fetch from data segment
    issue(2'b00, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 1, 0, 0, 0, 1, 0, 1, "R8");
    // R8: read from execute-only code
    issue(2'b01, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 1, 0, 0, 1, 0, 0, 1, "R8");
    // R8: read from readable code
    issue(2'b01, 32'h8, 3'd2, 32'h40, 32'hFF, 0, 1, 0, 0, 1, 1, 0, 1, "R8");
    // R9: write to code
    issue(2'b10, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 1, 0, 0, 1, 1, 0, 1, "R9");
    // R9: write to read-only data
    issue(2'b10, 32'h0, 3'd1, 32'h0, 32'hFF, 0, 1, 0, 0, 0, 0, 0, 1, "R9");
    // R10: write passes, address wraps modulo 2^32
    issue(2'b10, 32'h20, 3'd4, 32'hFFFFFFF0, 32'hFFFF, 0, 1, 2, 2, 0, 1, 2, 1, "R10");
    idle(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule